// File: doc/BRIEF.md
# High-Speed Receive Word Deserializer

This block sits between the sampled high-speed line bit and the serial interface engine. It takes one recovered line bit per strobe and decodes it from NRZI. It then finds the start-of-packet pattern and strips the stuffed zeros. The data is packed least-significant bit first into 16-bit words, with the first received byte in the low lane. A run of seven decoded ones is a stuff violation, and it closes the packet. The bits that form that violation are delivered as an end byte in whichever lane they fall. Packets with an odd number of bytes therefore end cleanly.

Two flags on the last word tell the receiver where the end byte sits. It is either in the high lane, next to the final data byte, or alone in the low lane of an extra word. The output is a valid-only stream with no back-pressure. A word is offered for exactly one cycle, and the sink must take it in that cycle. The block runs only when the mode input selects high-speed operation and the direction input selects receive.

Top module: `hs_rx_deser`

## Requirements
- R1: After reset, `word_valid_o`, `word_last_o`, `word_bserr_o` and `word_o` are all zero.
- R2: A decoded bit is 1 when the line bit equals the previous accepted line bit, and 0 when it differs. The line is taken as 1 on entry to receive operation.
- R3: A packet starts after at least 6 consecutive decoded zeros followed by a decoded 1. With only 5 zeros no packet starts. The closing 1 of that pattern counts toward the first run of ones.
- R4: Inside a packet, a decoded 0 that follows six consecutive decoded ones is removed from the data.
- R5: Data bits fill each 16-bit word least-significant bit first. Bits 7:0 hold the earlier byte and bits 15:8 the later one. Each finished word appears on `word_o` with `word_valid_o` high for one cycle. There is no back-pressure.
- R6: A decoded 1 arriving after six consecutive ones is a stuff violation. It ends the packet and is itself kept as a data bit, so a regular end pattern (0 then seven 1s) yields the end byte 0xFE.
- R7: If the end byte falls in the high lane, the final word carries the last data byte in bits 7:0 and the end byte in bits 15:8, with `word_last_o`=1 and `word_bserr_o`=1.
- R8: If the end byte falls in the low lane, an extra word carries it in bits 7:0, with bits 15:8 = 0x00, `word_last_o`=1 and `word_bserr_o`=0.
- R9: If the violation does not land on a byte boundary, the end byte is padded with 1s up to the next byte boundary before it is delivered.
- R10: Words before the final one have `word_last_o`=0 and `word_bserr_o`=0. After the final word, `word_valid_o` stays low until a new packet start.
- R11: The block receives only while `mode_i`=2'b10 and `dir_i`=0. Otherwise no word is produced, and a packet in progress is dropped without a final word.
- R12: Line bits presented while `line_valid_i` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating state; 2'b10 selects high-speed |
| dir_i | input | 1 | Bus direction; 0 selects receive |
| line_bit_i | input | 1 | Sampled line bit (NRZI encoded) |
| line_valid_i | input | 1 | Strobe marking `line_bit_i` as a new bit |
| word_o | output | 16 | Received word, first byte in bits 7:0 |
| word_valid_o | output | 1 | Word qualifier, one cycle per word |
| word_last_o | output | 1 | Marks the final word of a packet |
| word_bserr_o | output | 1 | With last: end byte is in bits 15:8 |

## Verification
Two events can fall in one cycle: the stuff-violation bit that ends the packet, and the bit that completes a 16-bit word. Odd-length packets always put the end byte in the high lane, so the end flags and the word completion coincide. Even-length packets make the violation coincide with the half-word boundary instead. The bench sends both kinds at random lengths, with random gaps in the bit strobe. For each packet it judges the exact list of words, including the final word's contents and flags. It also checks that no word appears after the final one.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;
  typedef enum logic {FR_HUNT, FR_DATA} fr_state_e;
  localparam logic [1:0] MODE_HS = 2'b10;
endpackage

// File: rtl/hsrx_nrzi.sv
module hsrx_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic line_v,
  input  logic line_b,
  output logic dec_v,
  output logic dec_b
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b1;
      dec_v <= 1'b0;
      dec_b <= 1'b0;
    end else begin
      dec_v <= act && line_v;
      if (!act) begin
        prev <= 1'b1;
      end else if (line_v) begin
        dec_b <= (line_b == prev);   // R2: no change decodes as 1
        prev  <= line_b;
      end
    end
  end
endmodule

// File: rtl/hsrx_frame.sv
module hsrx_frame
  import hsrx_pkg::*;
#(
  parameter int SYNC_ZEROS = 6,
  parameter int STUFF_RUN  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic dec_v,
  input  logic dec_b,
  output logic bit_v,
  output logic bit_d,
  output logic sop,
  output logic eop
);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_ZEROS);
  localparam logic [OW-1:0] OMAX = OW'(STUFF_RUN);

  fr_state_e       state;
  logic [ZW-1:0]   zcnt;
  logic [OW-1:0]   ones;
  logic            in_data, at_run;

  always_comb begin
    in_data = (state == FR_DATA);
    at_run  = (ones == OMAX);
    bit_v   = dec_v && in_data && !(at_run && !dec_b);   // R4 drop
    bit_d   = dec_b;
    eop     = dec_v && in_data && at_run && dec_b;        // R6
    sop     = dec_v && !in_data && dec_b && (zcnt == ZMAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !act) begin
      state <= FR_HUNT;
      zcnt  <= '0;
      ones  <= '0;
    end else if (dec_v) begin
      case (state)
        FR_HUNT: begin
          if (!dec_b) begin
            if (zcnt != ZMAX) zcnt <= zcnt + 1'b1;
          end else if (zcnt == ZMAX) begin
            state <= FR_DATA;
            zcnt  <= '0;
            ones  <= OW'(1);     // R3: closing 1 counts toward the run
          end else begin
            zcnt <= '0;
          end
        end
        default: begin
          if (at_run) begin
            ones <= '0;
            if (dec_b) state <= FR_HUNT;
          end else begin
            ones <= dec_b ? ones + 1'b1 : '0;
          end
        end
      endcase
    end
  end

  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= OMAX);
  a_r6_no_data_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !bit_v);
endmodule

// File: rtl/hsrx_pack.sv
module hsrx_pack #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              bit_v,
  input  logic              bit_d,
  input  logic              sop,
  input  logic              eop,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              bserr_o
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int CW     = $clog2(WORD_W);
  localparam logic [CW:0] FULL_C = (CW+1)'(WORD_W);
  localparam logic [CW:0] HALF_C = (CW+1)'(BYTE_W);

  logic [WORD_W-1:0] sr, nsr;
  logic [CW-1:0]     cnt;
  logic [CW:0]       ncnt;
  logic              live, flush, ins, full, half, ending;

  always_comb begin
    ins    = flush || (live && bit_v);
    nsr    = {flush | bit_d, sr[WORD_W-1:1]};       // R5 LSB first
    ncnt   = {1'b0, cnt} + 1'b1;
    full   = (ncnt == FULL_C);
    half   = (ncnt == HALF_C);
    ending = flush || (live && eop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; live <= 1'b0; flush <= 1'b0;
      data_o <= '0; valid_o <= 1'b0; last_o <= 1'b0; bserr_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      bserr_o <= 1'b0;
      if (!act) begin                 // R11 drop packet
        live <= 1'b0; flush <= 1'b0; cnt <= '0;
      end else if (sop) begin
        live <= 1'b1; flush <= 1'b0; cnt <= '0;
      end else if (ins) begin
        sr  <= nsr;
        cnt <= full ? '0 : ncnt[CW-1:0];
        if (full) begin
          data_o  <= nsr;
          valid_o <= 1'b1;
          last_o  <= ending;          // R7 end byte in high lane
          bserr_o <= ending;
          if (ending) begin live <= 1'b0; flush <= 1'b0; end
        end else if (half && ending) begin
          data_o  <= {{BYTE_W{1'b0}}, nsr[WORD_W-1:BYTE_W]};  // R8
          valid_o <= 1'b1;
          last_o  <= 1'b1;
          live    <= 1'b0;
          flush   <= 1'b0;
        end else if (ending) begin
          flush <= 1'b1;              // R9 pad with ones
        end
      end
    end
  end

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !valid_o);
  a_r10_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  a_r7_bserr_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    bserr_o |-> last_o);
  a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);
  a_r8_pad_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !bserr_o) |-> (data_o[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/hs_rx_deser.sv
module hs_rx_deser
  import hsrx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SYNC_ZEROS = 6,
  parameter int STUFF_RUN  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              dir_i,
  input  logic              line_bit_i,
  input  logic              line_valid_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              word_last_o,
  output logic              word_bserr_o
);
  logic act, dec_v, dec_b, bit_v, bit_d, sop, eop;

  assign act = (mode_i == MODE_HS) && !dir_i;   // R11

  hsrx_nrzi u_nrzi (
    .clk(clk), .rst_n(rst_n), .act(act),
    .line_v(line_valid_i), .line_b(line_bit_i),
    .dec_v(dec_v), .dec_b(dec_b)
  );

  hsrx_frame #(.SYNC_ZEROS(SYNC_ZEROS), .STUFF_RUN(STUFF_RUN)) u_frame (
    .clk(clk), .rst_n(rst_n), .act(act),
    .dec_v(dec_v), .dec_b(dec_b),
    .bit_v(bit_v), .bit_d(bit_d), .sop(sop), .eop(eop)
  );

  hsrx_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .act(act),
    .bit_v(bit_v), .bit_d(bit_d), .sop(sop), .eop(eop),
    .data_o(word_o), .valid_o(word_valid_o),
    .last_o(word_last_o), .bserr_o(word_bserr_o)
  );
endmodule

// File: tb/test_hs_rx_deser.sv
`timescale 1ns/1ps
module test_hs_rx_deser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'b10;
  logic dir_i = 1'b0;
  logic line_bit_i = 1'b1;
  logic line_valid_i = 1'b0;
  logic [15:0] word_o;
  logic word_valid_o, word_last_o, word_bserr_o;

  always #2 clk = ~clk;

  hs_rx_deser i_hs_rx_deser (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
    .line_bit_i(line_bit_i), .line_valid_i(line_valid_i),
    .word_o(word_o), .word_valid_o(word_valid_o),
    .word_last_o(word_last_o), .word_bserr_o(word_bserr_o)
  );

  int checks = 0;
  int errors = 0;
  logic line = 1'b1;
  int ones_run = 0;
  bit gaps = 1'b0;

  logic [7:0]  pk [64];
  logic [15:0] exp_w [64];
  logic        exp_l [64];
  logic        exp_e [64];
  int          exp_n;
  logic [15:0] got_w [64];
  logic        got_l [64];
  logic        got_e [64];
  int          got_n = 0;

  always @(negedge clk) begin
    if (word_valid_o && got_n < 64) begin
      got_w[got_n] = word_o;
      got_l[got_n] = word_last_o;
      got_e[got_n] = word_bserr_o;
      got_n = got_n + 1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic tick_bit(input logic b);
    if (gaps && ($urandom % 4) == 0) begin
      line_valid_i = 1'b0;
      line_bit_i   = $urandom % 2;   // R12 noise while strobe is low
      @(negedge clk);
    end
    if (!b) line = ~line;
    line_bit_i   = line;
    line_valid_i = 1'b1;
    @(negedge clk);
    line_valid_i = 1'b0;
    line_bit_i   = line;
  endtask

  task automatic send_sync(input int zeros);
    for (int i = 0; i < zeros; i++) tick_bit(1'b0);
    tick_bit(1'b1);
    ones_run = 1;
  endtask

  task automatic send_data_bit(input logic b);
    tick_bit(b);
    ones_run = b ? ones_run + 1 : 0;
    if (ones_run == 6) begin
      tick_bit(1'b0);
      ones_run = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic send_eop();
    tick_bit(1'b0);
    for (int i = 0; i < 7; i++) tick_bit(1'b1);
  endtask

  task automatic idle(input int n);
    line_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Expected words from R5, R7, R8, R10
  task automatic build_expect(input int n);
    exp_n = 0;
    for (int i = 0; i + 1 < n; i += 2) begin
      exp_w[exp_n] = {pk[i+1], pk[i]};
      exp_l[exp_n] = 1'b0; exp_e[exp_n] = 1'b0;
      exp_n++;
    end
    if (n % 2 == 1) begin
      exp_w[exp_n] = {8'hFE, pk[n-1]};
      exp_l[exp_n] = 1'b1; exp_e[exp_n] = 1'b1;
    end else begin
      exp_w[exp_n] = {8'h00, 8'hFE};
      exp_l[exp_n] = 1'b1; exp_e[exp_n] = 1'b0;
    end
    exp_n++;
  endtask

  task automatic compare(input string req);
    check(got_n == exp_n, {req, " word count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_w[i] == exp_w[i], {req, " data"}, got_w[i], exp_w[i]);
      check({got_l[i], got_e[i]} == {exp_l[i], exp_e[i]},
            {req, " R10 flags"}, {got_l[i], got_e[i]}, {exp_l[i], exp_e[i]});
    end
  endtask

  task automatic run_packet(input int n, input string req);
    got_n = 0;
    build_expect(n);
    send_sync(8);
    for (int i = 0; i < n; i++) send_byte(pk[i]);
    send_eop();
    idle(24);
    compare(req);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    check({word_valid_o, word_last_o, word_bserr_o} == 3'b000, "R1 flags",
          {word_valid_o, word_last_o, word_bserr_o}, 0);
    check(word_o == 16'h0000, "R1 data", word_o, 0);
    rst_n = 1'b1;
    idle(4);

    // R2 R5 R8 even length
    pk[0] = 8'h3C; pk[1] = 8'hA1;
    run_packet(2, "R2 R5 R8 even");
    // R7 odd length
    pk[0] = 8'h01; pk[1] = 8'h80; pk[2] = 8'h5A;
    run_packet(3, "R7 odd");
    // R4 R3 stuffing including the run opened by the start pattern
    pk[0] = 8'h1F; pk[1] = 8'hFF; pk[2] = 8'hFF; pk[3] = 8'h7E;
    run_packet(4, "R4 R3 stuffed");
    // R8 empty packet, R7 single byte
    run_packet(0, "R8 empty");
    pk[0] = 8'hC3;
    run_packet(1, "R7 single");

    // R3: five zeros do not open a packet
    got_n = 0;
    send_sync(5);
    idle(24);
    check(got_n == 0, "R3 short start", got_n, 0);
    // R3: exactly six zeros do
    pk[0] = 8'h96; pk[1] = 8'h0F;
    got_n = 0; build_expect(2);
    send_sync(6); send_byte(pk[0]); send_byte(pk[1]); send_eop();
    idle(24);
    compare("R3 six zeros");

    // R9 misaligned end: A5, bits 1,0, end pattern
    got_n = 0;
    send_sync(8); send_byte(8'hA5); send_data_bit(1'b1); send_data_bit(1'b0);
    send_eop(); idle(24);
    exp_n = 2;
    exp_w[0] = 16'hF9A5; exp_l[0] = 1'b0; exp_e[0] = 1'b0;
    exp_w[1] = 16'h00FF; exp_l[1] = 1'b1; exp_e[1] = 1'b0;
    compare("R9 padded");

    // R11 wrong mode, wrong direction
    pk[0] = 8'h11; pk[1] = 8'h22;
    mode_i = 2'b01; got_n = 0;
    send_sync(8); send_byte(8'h11); send_byte(8'h22); send_eop(); idle(24);
    check(got_n == 0, "R11 mode", got_n, 0);
    mode_i = 2'b10; dir_i = 1'b1; line = 1'b1; got_n = 0;
    send_sync(8); send_byte(8'h11); send_byte(8'h22); send_eop(); idle(24);
    check(got_n == 0, "R11 dir", got_n, 0);
    // R11 drop mid packet
    dir_i = 1'b0; line = 1'b1; line_bit_i = 1'b1; idle(2); got_n = 0;
    send_sync(8); send_byte(8'h44);
    mode_i = 2'b00; line = 1'b1; line_bit_i = 1'b1; idle(24);
    check(got_n == 0, "R11 abort", got_n, 0);
    mode_i = 2'b10; idle(2);
    run_packet(2, "R11 resume");

    // R12 R5 random packets with strobe gaps
    gaps = 1'b1;
    for (int p = 0; p < 30; p++) begin
      int n;
      n = $urandom % 13;
      for (int i = 0; i < n; i++) pk[i] = $urandom % 256;
      run_packet(n, "R12 R5 random");
    end
    gaps = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule